// File: doc/BRIEF.md
# Dual-Half Address Generation Unit

This block produces data and program memory addresses for a 24-bit signal processor. It holds eight 16-bit pointer registers, eight 16-bit step registers and eight 16-bit mode registers. They are organised as a low half (indices 0 to 3) and a high half (indices 4 to 7). Each half has its own copy of the same address arithmetic unit, so one pointer in each half can be post-updated in every clock cycle. The mode register paired with a pointer decides how that pointer moves: plain 16-bit wrap-around, circular buffering of any length up to 32768, or reverse-carry stepping for FFT data reordering.

All twenty-four registers can be read and written over a 24-bit data bus. Reads are zero-extended and writes keep only the low 16 bits. Three independent selectors route any pointer onto the X data address, Y data address and program address outputs. These outputs show the pointer value as it stands before an update that happens in the same cycle. Instruction decoding, the memories and the pipeline around the unit are supplied by the surrounding design.

Top module: `agu_top`

## Requirements
- R1: While reset is asserted and right after it is released, every pointer and step register reads 0 and every mode register reads 16'hFFFF.
- R2: A read returns the selected 16-bit register in bits 15:0 of `gdb_rd_data` in the same cycle, with bits 23:16 zero. The register class code is 0 for pointer, 1 for step and 2 for mode. Code 3 reads as zero.
- R3: A bus write stores `gdb_wr_data[15:0]` into the selected register at the clock edge and drops bits 23:16. A write with class code 3 changes no register.
- R4: The update codes are 0 none, 1 add one, 2 subtract one, 3 add the step register of the same index, and 4 subtract it; codes 5 to 7 act as none. With mode 16'hFFFF the pointer wraps modulo 2^16.
- R5: A mode value L in 1..32767 gives a circular buffer of length L+1. The buffer lies in a block of size 2^k, the smallest power of two at or above L+1, aligned to that size. Moving past either end of the buffer wraps to the other end, and the bits above the block never change.
- R6: Mode value 0 gives reverse-carry addition: the step is added with carries running from bit 15 towards bit 0. Starting from 0 with step 4, repeated adds visit 4, 2, 6, 1.
- R7: Mode values 16'h8000 to 16'hFFFE behave like 16'hFFFF.
- R8: The low update selector addresses pointers 0 to 3 and the high one addresses pointers 4 to 7. Both halves can update in the same cycle without affecting each other.
- R9: When a bus write and an update target the same pointer in one cycle, the written value is stored.
- R10: `xab`, `yab` and `pab` each show the pointer picked by their own 3-bit selector. During a cycle that updates that pointer, they show the value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| gdb_wr_en | input | 1 | Bus write strobe |
| gdb_wr_kind | input | 2 | Class of register written (0 pointer, 1 step, 2 mode) |
| gdb_wr_idx | input | 3 | Index of register written |
| gdb_wr_data | input | 24 | Bus write data |
| gdb_rd_kind | input | 2 | Class of register read |
| gdb_rd_idx | input | 3 | Index of register read |
| gdb_rd_data | output | 24 | Zero-extended read data |
| lo_upd_op | input | 3 | Update code for the low half |
| lo_upd_sel | input | 2 | Pointer 0..3 to update |
| hi_upd_op | input | 3 | Update code for the high half |
| hi_upd_sel | input | 2 | Pointer 4..7 to update (local index) |
| xab_sel | input | 3 | Pointer shown on the X address output |
| yab_sel | input | 3 | Pointer shown on the Y address output |
| pab_sel | input | 3 | Pointer shown on the program address output |
| xab | output | 16 | X data address |
| yab | output | 16 | Y data address |
| pab | output | 16 | Program address |

## Verification
The circular-buffer property assumes the update sequence keeps the pointer's offset inside the buffer and uses a step no larger than the buffer length. Every modulo stimulus therefore loads pointers at offsets below L+1 and uses steps of at most L+1. The checks on write width and write priority take the read selectors as steady for one cycle after a write. The bench keeps the selectors steady around every write it checks, and it applies updates only after the operands of the target pointer have been loaded over the bus.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int ADDR_W  = 16;
    localparam int BUS_W   = 24;
    localparam int NUM_REG = 8;

    typedef enum logic [1:0] {
        KIND_PTR  = 2'd0,
        KIND_STEP = 2'd1,
        KIND_MODE = 2'd2,
        KIND_RSV  = 2'd3
    } reg_kind_e;

    typedef enum logic [2:0] {
        UPD_NONE  = 3'd0,
        UPD_INC   = 3'd1,
        UPD_DEC   = 3'd2,
        UPD_ADDN  = 3'd3,
        UPD_SUBN  = 3'd4
    } upd_op_e;

    typedef enum logic [1:0] {
        MODE_LINEAR,
        MODE_MODULO,
        MODE_REVCARRY
    } addr_mode_e;
endpackage

// File: rtl/agu_addr_alu.sv
module agu_addr_alu
    import agu_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] mode_word,
    input  logic [2:0]    op,
    output logic          go,
    output logic [AW-1:0] nxt
);
    function automatic logic [AW-1:0] bit_rev(input logic [AW-1:0] v);
        logic [AW-1:0] o;
        for (int k = 0; k < AW; k++) o[k] = v[AW-1-k];
        return o;
    endfunction

    function automatic logic [AW-1:0] smear(input logic [AW-1:0] v);
        logic [AW-1:0] o;
        o = v;
        for (int k = 1; k < AW; k++) o = o | (o >> 1);
        return o;
    endfunction

    addr_mode_e    mode;
    logic          up;
    logic [AW-1:0] mag;
    logic [AW-1:0] delta;
    logic [AW-1:0] lin_v;
    logic [AW-1:0] rev_v;
    logic [AW-1:0] blk_mask;
    logic [AW-1:0] blk_base;
    logic [AW:0]   modulus;
    logic [AW:0]   off_s;
    logic [AW-1:0] mod_v;

    always_comb begin
        go = 1'b0;
        up = 1'b0;
        unique case (upd_op_e'(op))
            UPD_INC:  begin go = 1'b1; up = 1'b1; end
            UPD_DEC:  begin go = 1'b1; up = 1'b0; end
            UPD_ADDN: begin go = 1'b1; up = 1'b1; end
            UPD_SUBN: begin go = 1'b1; up = 1'b0; end
            default:  begin go = 1'b0; up = 1'b0; end
        endcase
        mag   = (op == UPD_ADDN || op == UPD_SUBN) ? step : AW'(1);
        delta = up ? mag : (~mag + AW'(1));
    end

    always_comb begin
        if (mode_word == '0)
            mode = MODE_REVCARRY;
        else if (!mode_word[AW-1])
            mode = MODE_MODULO;
        else
            mode = MODE_LINEAR;
    end

    always_comb begin
        lin_v    = ptr + delta;
        rev_v    = bit_rev(bit_rev(ptr) + bit_rev(delta));
        blk_mask = smear(mode_word);
        blk_base = ptr & ~blk_mask;
        modulus  = {1'b0, mode_word} + (AW+1)'(1);
        if (up) begin
            off_s = {1'b0, ptr & blk_mask} + {1'b0, mag};
            if (off_s >= modulus) off_s = off_s - modulus;
        end else begin
            off_s = {1'b0, ptr & blk_mask} - {1'b0, mag};
            if (off_s[AW]) off_s = off_s + modulus;
        end
        mod_v = blk_base | (off_s[AW-1:0] & blk_mask);
    end

    always_comb begin
        unique case (mode)
            MODE_REVCARRY: nxt = rev_v;
            MODE_MODULO:   nxt = mod_v;
            default:       nxt = lin_v;
        endcase
    end
endmodule

// File: rtl/agu_half.sv
module agu_half
    import agu_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NH = NUM_REG / 2,
    localparam int SW = $clog2(NH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_kind,
    input  logic [SW-1:0]        wr_sel,
    input  logic [AW-1:0]        wr_val,
    input  logic [2:0]           upd_op,
    input  logic [SW-1:0]        upd_sel,
    output logic [NH-1:0][AW-1:0] ptr_q,
    output logic [NH-1:0][AW-1:0] step_q,
    output logic [NH-1:0][AW-1:0] mode_q
);
    logic [AW-1:0] ptr_mem  [NH];
    logic [AW-1:0] step_mem [NH];
    logic [AW-1:0] mode_mem [NH];
    logic          alu_go;
    logic [AW-1:0] alu_nxt;

    agu_addr_alu #(.AW(AW)) alu_i (
        .ptr       (ptr_mem[upd_sel]),
        .step      (step_mem[upd_sel]),
        .mode_word (mode_mem[upd_sel]),
        .op        (upd_op),
        .go        (alu_go),
        .nxt       (alu_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NH; i++) begin
                ptr_mem[i]  <= '0;
                step_mem[i] <= '0;
                mode_mem[i] <= '1;
            end
        end else begin
            if (alu_go) ptr_mem[upd_sel] <= alu_nxt;
            if (wr_en) begin
                unique case (reg_kind_e'(wr_kind))
                    KIND_PTR:  ptr_mem[wr_sel]  <= wr_val;
                    KIND_STEP: step_mem[wr_sel] <= wr_val;
                    KIND_MODE: mode_mem[wr_sel] <= wr_val;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NH; i++) begin
            ptr_q[i]  = ptr_mem[i];
            step_q[i] = step_mem[i];
            mode_q[i] = mode_mem[i];
        end
    end
endmodule

// File: rtl/agu_out_mux.sv
module agu_out_mux
    import agu_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NR = NUM_REG,
    parameter int NB = 3,
    localparam int IW = $clog2(NR)
) (
    input  logic [NR-1:0][AW-1:0] regs,
    input  logic [NB-1:0][IW-1:0] sel,
    output logic [NB-1:0][AW-1:0] bus_out
);
    for (genvar b = 0; b < NB; b++) begin : g_bus
        assign bus_out[b] = regs[sel[b]];
    end
endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BUS_W,
    parameter int NR = NUM_REG,
    localparam int NH = NR / 2,
    localparam int IW = $clog2(NR),
    localparam int SW = $clog2(NH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gdb_wr_en,
    input  logic [1:0]    gdb_wr_kind,
    input  logic [IW-1:0] gdb_wr_idx,
    input  logic [BW-1:0] gdb_wr_data,
    input  logic [1:0]    gdb_rd_kind,
    input  logic [IW-1:0] gdb_rd_idx,
    output logic [BW-1:0] gdb_rd_data,
    input  logic [2:0]    lo_upd_op,
    input  logic [SW-1:0] lo_upd_sel,
    input  logic [2:0]    hi_upd_op,
    input  logic [SW-1:0] hi_upd_sel,
    input  logic [IW-1:0] xab_sel,
    input  logic [IW-1:0] yab_sel,
    input  logic [IW-1:0] pab_sel,
    output logic [AW-1:0] xab,
    output logic [AW-1:0] yab,
    output logic [AW-1:0] pab
);
    logic [NR-1:0][AW-1:0] ptr_all;
    logic [NR-1:0][AW-1:0] step_all;
    logic [NR-1:0][AW-1:0] mode_all;
    logic [2:0][AW-1:0]    mux_out;
    logic [AW-1:0]         rd_word;
    logic                  unused_wr_hi;

    assign unused_wr_hi = ^gdb_wr_data[BW-1:AW];

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic            h_wr_en;
        logic [2:0]      h_op;
        logic [SW-1:0]   h_sel;
        assign h_wr_en = gdb_wr_en && (gdb_wr_idx[IW-1] == 1'(h));
        assign h_op    = (h == 0) ? lo_upd_op  : hi_upd_op;
        assign h_sel   = (h == 0) ? lo_upd_sel : hi_upd_sel;

        agu_half #(.AW(AW), .NH(NH)) half_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (h_wr_en),
            .wr_kind (gdb_wr_kind),
            .wr_sel  (gdb_wr_idx[SW-1:0]),
            .wr_val  (gdb_wr_data[AW-1:0]),
            .upd_op  (h_op),
            .upd_sel (h_sel),
            .ptr_q   (ptr_all [h*NH +: NH]),
            .step_q  (step_all[h*NH +: NH]),
            .mode_q  (mode_all[h*NH +: NH])
        );
    end

    always_comb begin
        unique case (reg_kind_e'(gdb_rd_kind))
            KIND_PTR:  rd_word = ptr_all[gdb_rd_idx];
            KIND_STEP: rd_word = step_all[gdb_rd_idx];
            KIND_MODE: rd_word = mode_all[gdb_rd_idx];
            default:   rd_word = '0;
        endcase
        gdb_rd_data = {{(BW-AW){1'b0}}, rd_word};
    end

    agu_out_mux #(.AW(AW), .NR(NR), .NB(3)) mux_i (
        .regs    (ptr_all),
        .sel     ({pab_sel, yab_sel, xab_sel}),
        .bus_out (mux_out)
    );

    assign xab = mux_out[0];
    assign yab = mux_out[1];
    assign pab = mux_out[2];
endmodule

// File: rtl/agu_chk.sv
module agu_chk
    import agu_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BUS_W,
    parameter int NR = NUM_REG,
    localparam int IW = $clog2(NR),
    localparam int SW = $clog2(NR / 2)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [1:0]            wr_kind,
    input logic [IW-1:0]         wr_idx,
    input logic [BW-1:0]         wr_data,
    input logic [1:0]            rd_kind,
    input logic [IW-1:0]         rd_idx,
    input logic [BW-1:0]         rd_data,
    input logic [2:0]            lo_op,
    input logic [SW-1:0]         lo_sel,
    input logic [2:0]            hi_op,
    input logic [SW-1:0]         hi_sel,
    input logic [NR-1:0][AW-1:0] ptr_all,
    input logic [NR-1:0][AW-1:0] mode_all
);
    function automatic logic [AW-1:0] fill_down(input logic [AW-1:0] v);
        logic [AW-1:0] o;
        o = '0;
        for (int k = AW-1; k >= 0; k--) o[k] = o[k] | (k == AW-1 ? v[k] : (o[k+1] | v[k]));
        return o;
    endfunction

    logic [IW-1:0] lo_idx;
    logic [IW-1:0] hi_idx;
    logic          lo_clash;
    logic          hi_clash;
    logic [AW-1:0] hi_mode;
    logic [AW-1:0] hi_mask;
    logic          hi_circ;

    assign lo_idx   = {1'b0, lo_sel};
    assign hi_idx   = {1'b1, hi_sel};
    assign lo_clash = wr_en && wr_kind == KIND_PTR && wr_idx == lo_idx;
    assign hi_clash = wr_en && wr_kind == KIND_PTR && wr_idx == hi_idx;
    assign hi_mode  = mode_all[hi_idx];
    assign hi_mask  = fill_down(hi_mode);
    assign hi_circ  = hi_mode != '0 && !hi_mode[AW-1];

    // R1
    mode_reset_chk: assert property (@(posedge clk)
        $rose(rst_n) && rd_kind == KIND_MODE |-> rd_data == {{(BW-AW){1'b0}}, {AW{1'b1}}});

    // R3
    wr_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_kind != KIND_RSV && rd_kind == wr_kind && rd_idx == wr_idx
        |=> !$stable(rd_kind) || !$stable(rd_idx)
            || rd_data == {{(BW-AW){1'b0}}, $past(wr_data[AW-1:0])});

    // R4
    lin_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_op == UPD_INC && mode_all[lo_idx] == {AW{1'b1}} && !lo_clash
        |=> ptr_all[$past(lo_idx)] == $past(ptr_all[lo_idx]) + AW'(1));

    // R5
    mod_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_op inside {UPD_INC, UPD_DEC, UPD_ADDN, UPD_SUBN} && hi_circ && !hi_clash
        |=> (ptr_all[$past(hi_idx)] & ~$past(hi_mask)) == $past(ptr_all[hi_idx] & ~hi_mask));

    // R9
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_clash && lo_op inside {UPD_INC, UPD_DEC, UPD_ADDN, UPD_SUBN}
        |=> ptr_all[$past(wr_idx)] == $past(wr_data[AW-1:0]));
endmodule

bind agu_top agu_chk #(.AW(AW), .BW(BW), .NR(NR)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (gdb_wr_en),
    .wr_kind  (gdb_wr_kind),
    .wr_idx   (gdb_wr_idx),
    .wr_data  (gdb_wr_data),
    .rd_kind  (gdb_rd_kind),
    .rd_idx   (gdb_rd_idx),
    .rd_data  (gdb_rd_data),
    .lo_op    (lo_upd_op),
    .lo_sel   (lo_upd_sel),
    .hi_op    (hi_upd_op),
    .hi_sel   (hi_upd_sel),
    .ptr_all  (ptr_all),
    .mode_all (mode_all)
);

// File: tb/agu_top_tb_top.sv
`timescale 1ns/1ps
module agu_top_tb_top;
    localparam int WATCHDOG_CYC = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gdb_wr_en = 1'b0;
    logic [1:0]  gdb_wr_kind = '0;
    logic [2:0]  gdb_wr_idx = '0;
    logic [23:0] gdb_wr_data = '0;
    logic [1:0]  gdb_rd_kind = '0;
    logic [2:0]  gdb_rd_idx = '0;
    logic [23:0] gdb_rd_data;
    logic [2:0]  lo_upd_op = '0;
    logic [1:0]  lo_upd_sel = '0;
    logic [2:0]  hi_upd_op = '0;
    logic [1:0]  hi_upd_sel = '0;
    logic [2:0]  xab_sel = '0;
    logic [2:0]  yab_sel = '0;
    logic [2:0]  pab_sel = '0;
    logic [15:0] xab, yab, pab;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    agu_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .gdb_wr_en(gdb_wr_en), .gdb_wr_kind(gdb_wr_kind), .gdb_wr_idx(gdb_wr_idx),
        .gdb_wr_data(gdb_wr_data), .gdb_rd_kind(gdb_rd_kind), .gdb_rd_idx(gdb_rd_idx),
        .gdb_rd_data(gdb_rd_data), .lo_upd_op(lo_upd_op), .lo_upd_sel(lo_upd_sel),
        .hi_upd_op(hi_upd_op), .hi_upd_sel(hi_upd_sel), .xab_sel(xab_sel),
        .yab_sel(yab_sel), .pab_sel(pab_sel), .xab(xab), .yab(yab), .pab(pab)
    );

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] kind, input logic [2:0] idx, input logic [23:0] data);
        @(negedge clk);
        gdb_wr_en = 1'b1; gdb_wr_kind = kind; gdb_wr_idx = idx; gdb_wr_data = data;
        @(negedge clk);
        gdb_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] kind, input logic [2:0] idx,
                          input logic [23:0] exp);
        gdb_rd_kind = kind; gdb_rd_idx = idx;
        #1;
        check(tag, gdb_rd_data, exp);
    endtask

    task automatic step(input logic [2:0] lop, input logic [1:0] lsel,
                        input logic [2:0] hop, input logic [1:0] hsel);
        @(negedge clk);
        lo_upd_op = lop; lo_upd_sel = lsel; hi_upd_op = hop; hi_upd_sel = hsel;
        @(negedge clk);
        lo_upd_op = '0; hi_upd_op = '0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) begin
            rd_chk("R1 ptr reset", 2'd0, 3'(i), 24'h0);
            rd_chk("R1 step reset", 2'd1, 3'(i), 24'h0);
            rd_chk("R1 mode reset", 2'd2, 3'(i), 24'h00FFFF);
        end
    endtask

    task automatic t_bus();
        bus_wr(2'd0, 3'd3, 24'hABCDEF);
        rd_chk("R3 ptr trunc", 2'd0, 3'd3, 24'h00CDEF);
        bus_wr(2'd1, 3'd5, 24'h123456);
        rd_chk("R2 step zext", 2'd1, 3'd5, 24'h003456);
        bus_wr(2'd2, 3'd6, 24'hFF0010);
        rd_chk("R3 mode trunc", 2'd2, 3'd6, 24'h000010);
        bus_wr(2'd3, 3'd3, 24'h00AAAA);
        rd_chk("R3 rsv write ignored", 2'd0, 3'd3, 24'h00CDEF);
        rd_chk("R2 rsv reads zero", 2'd3, 3'd3, 24'h0);
        bus_wr(2'd2, 3'd6, 24'h00FFFF);
    endtask

    task automatic t_linear();
        bus_wr(2'd0, 3'd1, 24'h00FFFF);
        step(3'd1, 2'd1, 3'd0, 2'd0);
        rd_chk("R4 inc wrap", 2'd0, 3'd1, 24'h0);
        step(3'd2, 2'd1, 3'd0, 2'd0);
        rd_chk("R4 dec wrap", 2'd0, 3'd1, 24'h00FFFF);
        bus_wr(2'd0, 3'd2, 24'h000010);
        bus_wr(2'd1, 3'd2, 24'h000005);
        bus_wr(2'd1, 3'd1, 24'h000777);
        step(3'd4, 2'd2, 3'd0, 2'd0);
        rd_chk("R4 sub own step", 2'd0, 3'd2, 24'h00000B);
        step(3'd3, 2'd2, 3'd0, 2'd0);
        rd_chk("R4 add own step", 2'd0, 3'd2, 24'h000010);
        step(3'd6, 2'd2, 3'd0, 2'd0);
        rd_chk("R4 unused code no change", 2'd0, 3'd2, 24'h000010);
        bus_wr(2'd0, 3'd7, 24'h00FFFF);
        bus_wr(2'd2, 3'd7, 24'h008000);
        step(3'd0, 2'd0, 3'd1, 2'd3);
        rd_chk("R7 reserved mode linear", 2'd0, 3'd7, 24'h0);
    endtask

    task automatic t_modulo();
        bus_wr(2'd2, 3'd4, 24'h000004);
        bus_wr(2'd1, 3'd4, 24'h000003);
        bus_wr(2'd0, 3'd4, 24'h000104);
        step(3'd0, 2'd0, 3'd1, 2'd0);
        rd_chk("R5 inc wraps to base", 2'd0, 3'd4, 24'h000100);
        step(3'd0, 2'd0, 3'd2, 2'd0);
        rd_chk("R5 dec wraps to top", 2'd0, 3'd4, 24'h000104);
        bus_wr(2'd0, 3'd4, 24'h000103);
        step(3'd0, 2'd0, 3'd3, 2'd0);
        rd_chk("R5 add step wraps", 2'd0, 3'd4, 24'h000101);
        step(3'd0, 2'd0, 3'd4, 2'd0);
        rd_chk("R5 sub step wraps", 2'd0, 3'd4, 24'h000103);
        bus_wr(2'd2, 3'd1, 24'h000007);
        bus_wr(2'd0, 3'd1, 24'h000027);
        step(3'd1, 2'd1, 3'd0, 2'd0);
        rd_chk("R5 pow2 length wrap", 2'd0, 3'd1, 24'h000020);
    endtask

    task automatic t_revcarry();
        logic [15:0] seq [4] = '{16'h4, 16'h2, 16'h6, 16'h1};
        bus_wr(2'd2, 3'd5, 24'h0);
        bus_wr(2'd1, 3'd5, 24'h000004);
        bus_wr(2'd0, 3'd5, 24'h0);
        for (int i = 0; i < 4; i++) begin
            step(3'd0, 2'd0, 3'd3, 2'd1);
            rd_chk("R6 reverse carry order", 2'd0, 3'd5, {8'h0, seq[i]});
        end
    endtask

    task automatic t_parallel_mux();
        bus_wr(2'd0, 3'd0, 24'h000200);
        bus_wr(2'd0, 3'd4, 24'h000102);
        xab_sel = 3'd0; yab_sel = 3'd4; pab_sel = 3'd3;
        @(negedge clk);
        lo_upd_op = 3'd1; lo_upd_sel = 2'd0; hi_upd_op = 3'd1; hi_upd_sel = 2'd0;
        #1;
        check("R10 xab pre-update", {8'h0, xab}, 24'h000200);
        check("R10 yab pre-update", {8'h0, yab}, 24'h000102);
        check("R10 pab select", {8'h0, pab}, 24'h00CDEF);
        @(negedge clk);
        lo_upd_op = '0; hi_upd_op = '0;
        check("R8 low half updated", {8'h0, xab}, 24'h000201);
        check("R8 high half updated", {8'h0, yab}, 24'h000103);
        bus_wr(2'd0, 3'd2, 24'h0);
        @(negedge clk);
        gdb_wr_en = 1'b1; gdb_wr_kind = 2'd0; gdb_wr_idx = 3'd2; gdb_wr_data = 24'h005A5A;
        lo_upd_op = 3'd1; lo_upd_sel = 2'd2;
        @(negedge clk);
        gdb_wr_en = 1'b0; lo_upd_op = '0;
        rd_chk("R9 write beats update", 2'd0, 3'd2, 24'h005A5A);
    endtask

    initial begin
        #(WATCHDOG_CYC * 10);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_bus();
        t_linear();
        t_modulo();
        t_revcarry();
        t_parallel_mux();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule